// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer peripheral for a system that must be restarted when its software stops responding. A down-counter steps once for each cycle in which the tick strobe is high. Each tick stands for 0.6 seconds of real time. Software keeps the system alive by writing the reload register, which puts the programmed start value back into the counter. If software does not reload in time, the counter runs out. The first time this happens, the block raises a timeout flag and starts a second, equally long countdown on its own. If that second countdown also runs out while the first flag is still set, the block latches a system reset request.

Software talks to the block over a small synchronous register bus. A write takes effect at the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. The bus has no valid/ready handshake, so it never stalls and never applies back-pressure.

Software can do the following:
- halt the counter,
- read the current count,
- program the start value,
- clear status flags by writing 1 to them.

A separate no-reboot input vetoes the reset output. A sticky input tells the block, when it comes out of reset, whether the previous reset was caused by the watchdog.

Top module: `wdt2_top`

## Requirements
- R1: After reset, the halt bit (control register 0x08, bit 11) reads 1, the start value reads 4, the count reads 4, all status bits read 0 and `rst_req` is 0.
- R2: While the halt bit is 0, the count changes once on every clock edge where `tick_en` is 1. While the halt bit is 1, the count holds. The halt bit is written through byte lane 1 (`bus_be[1]`).
- R3: Any write to offset 0x00, with any byte strobe, loads the count from the start value. A read of 0x00 returns the count in bits [9:0] and zeros above them.
- R4: The start-value register at offset 0x12 holds 10 bits in [9:0]. A write changes only the bytes whose strobe is set (`bus_be[0]` selects bits 7:0, `bus_be[1]` selects bits 15:8). Bits 15:10 always read 0.
- R5: A write to offset 0x12 whose merged 10-bit result is 0, 1, 2 or 3 is discarded. The previous start value is kept.
- R6: A tick that finds the count at 0 is a first expiry when status register 1 (offset 0x04) bit 3 is clear. It sets that bit and reloads the count from the start value. The count therefore expires after start value + 1 ticks.
- R7: A further expiry while status register 1 bit 3 is set sets bit 1 of status register 2 (offset 0x06) and latches the reset request. The latch stays set until the block is reset, even if software clears the status bits.
- R8: Status register 1 bit 3 and status register 2 bits 1 and 2 are cleared by writing 1 to them with `bus_be[0]` set. Writing 0 leaves them unchanged. Clearing bit 3 between expiries restarts the two-stage sequence.
- R9: While `no_reboot` is 1, `rst_req` is 0 even after a second expiry. When `no_reboot` falls, a latched request appears on `rst_req`.
- R10: If `prior_wdt_reset` is 1 on the first clock edge after reset is released, bit 2 of status register 2 is set. It is not set again later while the block stays out of reset.
- R11: A reload write wins over a tick that arrives in the same cycle. The count takes the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one cycle per 0.6 s tick |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte strobes for write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| no_reboot | input | 1 | Vetoes the reset output |
| prior_wdt_reset | input | 1 | Sticky flag: the last reset came from the watchdog |
| rst_req | output | 1 | Level system-reset request |

## Verification
The hardest state to reach is a second expiry, because it needs two full uninterrupted countdowns with the first flag left set between them. The bench programs a small start value, releases the halt bit, and drives an exact number of ticks so that the count sits at zero just before each expiry tick. It then repeats the run with `no_reboot` held high, and once more after clearing the first flag in between, so that it can see both the veto and the restart of the sequence.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

  // Register byte offsets
  localparam logic [4:0] OFF_RELOAD = 5'h00;
  localparam logic [4:0] OFF_STS1   = 5'h04;
  localparam logic [4:0] OFF_STS2   = 5'h06;
  localparam logic [4:0] OFF_CTRL   = 5'h08;
  localparam logic [4:0] OFF_INIT   = 5'h12;

  // Bit positions inside those registers
  localparam int unsigned BIT_FIRST  = 3;   // status 1
  localparam int unsigned BIT_SECOND = 1;   // status 2
  localparam int unsigned BIT_BOOT   = 2;   // status 2
  localparam int unsigned BIT_HALT   = 11;  // control

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wdt2_flags_t;

endpackage

// File: rtl/wdt2_regfile.sv
module wdt2_regfile
  import wdt2_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned RST_INIT = 4,
  parameter int unsigned MIN_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [CNT_W-1:0]  cur_count,
  input  wdt2_flags_t       flags,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              halt,
  output logic [CNT_W-1:0]  init_val,
  output logic              reload,
  output wdt2_flags_t       clr
);

  localparam int unsigned BE_W      = DATA_W / 8;
  localparam int unsigned HALT_LANE = BIT_HALT / 8;

  logic              wr_reload, wr_sts1, wr_sts2, wr_ctrl, wr_init;
  logic [DATA_W-1:0] init_ext;
  logic [DATA_W-1:0] init_merged;
  logic [CNT_W-1:0]  init_cand;
  logic              init_ok;

  assign wr_reload = bus_wr && (bus_addr == ADDR_W'(OFF_RELOAD));
  assign wr_sts1   = bus_wr && (bus_addr == ADDR_W'(OFF_STS1));
  assign wr_sts2   = bus_wr && (bus_addr == ADDR_W'(OFF_STS2));
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_init   = bus_wr && (bus_addr == ADDR_W'(OFF_INIT));

  assign init_ext = DATA_W'(init_val);

  // Byte-lane merge for the start-value register
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign init_merged[g*8 +: 8] = bus_be[g] ? bus_wdata[g*8 +: 8]
                                             : init_ext[g*8 +: 8];
  end

  assign init_cand = init_merged[CNT_W-1:0];
  assign init_ok   = (32'(init_cand) >= MIN_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt     <= 1'b1;
      init_val <= CNT_W'(RST_INIT);
    end else begin
      if (wr_ctrl && bus_be[HALT_LANE])
        halt <= bus_wdata[BIT_HALT];
      if (wr_init && init_ok)
        init_val <= init_cand;
    end
  end

  assign reload       = wr_reload;
  assign clr.first    = wr_sts1 && bus_be[0] && bus_wdata[BIT_FIRST];
  assign clr.second   = wr_sts2 && bus_be[0] && bus_wdata[BIT_SECOND];
  assign clr.boot     = wr_sts2 && bus_be[0] && bus_wdata[BIT_BOOT];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_RELOAD): bus_rdata[CNT_W-1:0] = cur_count;
      ADDR_W'(OFF_STS1):   bus_rdata[BIT_FIRST] = flags.first;
      ADDR_W'(OFF_STS2): begin
        bus_rdata[BIT_SECOND] = flags.second;
        bus_rdata[BIT_BOOT]   = flags.boot;
      end
      ADDR_W'(OFF_CTRL):   bus_rdata[BIT_HALT]  = halt;
      ADDR_W'(OFF_INIT):   bus_rdata[CNT_W-1:0] = init_val;
      default:             bus_rdata = '0;
    endcase
  end

  // R5: a start value below the minimum never lands
  a_r5_invalid_init_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && !init_ok) |=> $stable(init_val));

  // R4: the stored start value never drops below the minimum
  a_r4_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
    32'(init_val) >= MIN_INIT);

endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned RST_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);

  logic advance;

  assign advance   = tick_en && !halt && !reload;
  assign underflow = advance && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= CNT_W'(RST_INIT);
    else if (reload)
      count <= init_val;
    else if (advance)
      count <= (count == '0) ? init_val : count - 1'b1;
  end

  // R2: a halted counter holds unless reloaded
  a_r2_frozen_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload) |=> $stable(count));

  // R11: reload beats a concurrent tick
  a_r11_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && tick_en) |=> (count == $past(init_val)));

endmodule

// File: rtl/wdt2_expiry.sv
module wdt2_expiry
  import wdt2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        underflow,
  input  wdt2_flags_t clr,
  input  logic        boot_src,
  output wdt2_flags_t flags,
  output logic        rst_pending
);

  logic boot_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags       <= '0;
      rst_pending <= 1'b0;
      boot_armed  <= 1'b1;
    end else begin
      boot_armed <= 1'b0;
      // stage one: set wins over a concurrent clear
      if (underflow)
        flags.first <= 1'b1;
      else if (clr.first)
        flags.first <= 1'b0;
      // stage two
      if (underflow && flags.first) begin
        flags.second <= 1'b1;
        rst_pending  <= 1'b1;
      end else if (clr.second) begin
        flags.second <= 1'b0;
      end
      // boot status is sampled once after reset release
      if (boot_armed && boot_src)
        flags.boot <= 1'b1;
      else if (clr.boot)
        flags.boot <= 1'b0;
    end
  end

  // R6: an expiry always leaves the first flag set
  a_r6_first_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> flags.first);

  // R7: the second stage needs the first flag
  a_r7_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pending) |-> $past(flags.first));

  // R7: the reset request latch only clears by reset
  a_r7_request_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pending |=> rst_pending);

  // R10: boot status cannot rise after the first cycle
  a_r10_boot_once: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_armed |=> !$rose(flags.boot));

endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned RST_INIT = 4,
  parameter int unsigned MIN_INIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                no_reboot,
  input  logic                prior_wdt_reset,
  output logic                rst_req
);

  logic             halt;
  logic             reload;
  logic             underflow;
  logic             rst_pending;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] count;
  wdt2_flags_t      flags;
  wdt2_flags_t      clr;

  wdt2_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RST_INIT(RST_INIT), .MIN_INIT(MIN_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .cur_count(count), .flags(flags), .bus_rdata(bus_rdata),
    .halt(halt), .init_val(init_val), .reload(reload), .clr(clr)
  );

  wdt2_countdown #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
    .reload(reload), .init_val(init_val), .count(count), .underflow(underflow)
  );

  wdt2_expiry u_exp (
    .clk(clk), .rst_n(rst_n), .underflow(underflow), .clr(clr),
    .boot_src(prior_wdt_reset), .flags(flags), .rst_pending(rst_pending)
  );

  assign rst_req = rst_pending && !no_reboot;

  // R9: with the veto released, a latched second expiry is visible
  a_r9_request_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.second && !no_reboot) |-> rst_req);

endmodule

// File: tb/wdt2_top_tb.sv
module wdt2_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_rdata;
  logic        no_reboot = 1'b0;
  logic        prior_wdt_reset = 1'b0;
  logic        rst_req;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  wdt2_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .no_reboot(no_reboot),
    .prior_wdt_reset(prior_wdt_reset), .rst_req(rst_req)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input int exp);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst_n = 1'b0;
    prior_wdt_reset = boot;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    chk_reg("R1 count", 5'h00, 4);
    chk_reg("R1 ctrl", 5'h08, 16'h0800);
    chk_reg("R1 init", 5'h12, 4);
    chk_reg("R1 sts1", 5'h04, 0);
    chk_reg("R1 sts2", 5'h06, 0);
    check("R1 rst_req", int'(rst_req), 0);
  endtask

  task automatic t_halt_and_count;
    ticks(3);
    chk_reg("R2 halted hold", 5'h00, 4);
    wr(5'h08, 16'h0000, 2'b01);            // wrong lane: halt unchanged
    chk_reg("R2 halt lane", 5'h08, 16'h0800);
    wr(5'h08, 16'h0000, 2'b10);
    ticks(3);
    chk_reg("R2 count down", 5'h00, 1);
    wr(5'h08, 16'h0800, 2'b10);
    ticks(2);
    chk_reg("R2 frozen again", 5'h00, 1);
    wr(5'h00, 16'h0000, 2'b01);
    chk_reg("R3 reload", 5'h00, 4);
  endtask

  task automatic t_init_value;
    wr(5'h12, 16'hFFFF, 2'b11);
    chk_reg("R4 upper zero", 5'h12, 16'h03FF);
    wr(5'h12, 16'h0002, 2'b01);
    chk_reg("R4 lane merge", 5'h12, 16'h0302);
    wr(5'h12, 16'h0000, 2'b11);
    chk_reg("R5 zero ignored", 5'h12, 16'h0302);
    wr(5'h12, 16'h0003, 2'b11);
    chk_reg("R5 three ignored", 5'h12, 16'h0302);
    wr(5'h12, 16'h0007, 2'b11);
    chk_reg("R4 valid write", 5'h12, 7);
  endtask

  task automatic t_reload_priority;
    wr(5'h00, 16'h0000, 2'b10);
    chk_reg("R3 reload any lane", 5'h00, 7);
    wr(5'h08, 16'h0000, 2'b10);
    ticks(2);
    chk_reg("R2 step", 5'h00, 5);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_be = 2'b01;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0; bus_be = '0;
    chk_reg("R11 reload wins", 5'h00, 7);
  endtask

  task automatic t_two_stage;
    do_reset(1'b0);
    wr(5'h12, 16'h0005, 2'b11);
    wr(5'h00, 16'h0000, 2'b01);
    wr(5'h08, 16'h0000, 2'b10);
    ticks(5);
    chk_reg("R6 at zero", 5'h00, 0);
    chk_reg("R6 no flag yet", 5'h04, 0);
    ticks(1);
    chk_reg("R6 first flag", 5'h04, 16'h0008);
    chk_reg("R6 auto reload", 5'h00, 5);
    ticks(5);
    check("R7 not yet", int'(rst_req), 0);
    ticks(1);
    chk_reg("R7 second flag", 5'h06, 16'h0002);
    check("R7 rst_req", int'(rst_req), 1);
    wr(5'h06, 16'h0002, 2'b01);
    wr(5'h04, 16'h0008, 2'b01);
    chk_reg("R8 second cleared", 5'h06, 0);
    check("R7 sticky request", int'(rst_req), 1);
  endtask

  task automatic t_w1c_restart;
    do_reset(1'b0);
    wr(5'h08, 16'h0000, 2'b10);
    ticks(5);
    chk_reg("R6 first at 5 ticks", 5'h04, 16'h0008);
    wr(5'h04, 16'h0000, 2'b01);
    chk_reg("R8 write zero keeps", 5'h04, 16'h0008);
    wr(5'h04, 16'h0008, 2'b10);
    chk_reg("R8 wrong lane keeps", 5'h04, 16'h0008);
    wr(5'h04, 16'h0008, 2'b01);
    chk_reg("R8 cleared", 5'h04, 0);
    ticks(5);
    chk_reg("R8 restart first", 5'h04, 16'h0008);
    chk_reg("R8 no second", 5'h06, 0);
    check("R8 no reset", int'(rst_req), 0);
  endtask

  task automatic t_no_reboot;
    no_reboot = 1'b1;
    do_reset(1'b0);
    wr(5'h08, 16'h0000, 2'b10);
    ticks(10);
    chk_reg("R9 second flag", 5'h06, 16'h0002);
    check("R9 vetoed", int'(rst_req), 0);
    @(negedge clk);
    no_reboot = 1'b0;
    #1;
    check("R9 veto lifted", int'(rst_req), 1);
  endtask

  task automatic t_boot_status;
    do_reset(1'b1);
    chk_reg("R10 boot set", 5'h06, 16'h0004);
    wr(5'h06, 16'h0004, 2'b01);
    repeat (3) @(negedge clk);
    chk_reg("R10 boot stays clear", 5'h06, 0);
    prior_wdt_reset = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    t_reset_state();
    t_halt_and_count();
    t_init_value();
    t_reload_priority();
    t_two_stage();
    t_w1c_restart();
    t_no_reboot();
    t_boot_status();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule